// File: doc/BRIEF.md
# Lockable Amplifier Configuration Register Bank

This block is the software-facing configuration store for a programmable-gain amplifier peripheral. A simple synchronous bus reaches it with a word address, a write strobe, 32-bit write data and a protected-access enable. Read data is combinational from the addressed register. The bank holds a control word, an input routing word, a 32-bit trim word, a constant identification word and a lock word. Every configuration field leaves the bank as its own decoded output port, so the analog front end never decodes register words itself.

Writes are gated twice. A write changes a configuration register only when the protected-access enable is high. It also needs the lock bit that guards that register to be clear. Lock bits can only be set and never cleared by software, so a register can be frozen until the next synchronous reset. Reserved positions read as zero and drop whatever is written into them. Offsets with no register behind them read as zero and take no writes.

Top module: `amp_cfg_bank`

## Requirements
- R1: After a synchronous reset every configuration field and every lock bit is 0. A read of word offset 5 returns 0x0000_0201.
- R2: A write to offset 0 with the protected enable high and lock bit 0 clear stores the data under mask 0x0000_83EF. The fields are: bit 0 enable, bits 3:1 filter select, bits 7:5 gain code, bit 8 output enable, bit 9 internal-gain pin enable and bit 15 chop level.
- R3: A write to offset 1 under the same conditions (lock bit 1) stores the data under mask 0x0000_7773. The fields are: bits 1:0 positive select, bits 6:4 negative select, bits 10:8 M select, bit 12 feedback-on-pin and bits 14:13 chop mode.
- R4: A write to offset 2 under the same conditions (lock bit 2) stores the data under mask 0x00FF_00FF. Bits 7:0 drive the N-pair trim and bits 23:16 drive the P-pair trim.
- R5: When the protected enable is low, no write changes any register, the lock register included.
- R6: Once lock bit k is set (k = 0, 1, 2 for offsets 0, 1, 2), writes to that register are ignored until reset. Writes to the other registers are unaffected.
- R7: A protected write to offset 6 ORs the data into the lock bits 0, 1, 2, 3 and 7. Writing 0 clears nothing. Lock bits 4 to 6 and all bits above 7 read as 0.
- R8: Offset 5 ignores writes.
- R9: Reads of offsets 3, 4 and 7 return 0, and writes there change nothing.
- R10: Reset clears the lock bits, so locked registers become writable again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Word offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| prot_en | input | 1 | Protected-access enable required by every write |
| bus_rdata | output | 32 | Read data of the addressed offset |
| amp_en | output | 1 | Amplifier enable |
| filt_sel | output | 3 | Filter resistor code |
| gain_code | output | 3 | Gain code |
| out_en | output | 1 | Output-to-pin enable |
| gain_pin_en | output | 1 | Internal gain node to pin enable |
| chop_level | output | 1 | Software chop level |
| pos_sel | output | 2 | Positive input select |
| neg_sel | output | 3 | Negative input select |
| m_sel | output | 3 | Feedback network select |
| fb_on_pin | output | 1 | Feedback-to-pin connection |
| chop_mode | output | 2 | Chopping mode |
| trim_p | output | 8 | P-pair offset trim |
| trim_n | output | 8 | N-pair offset trim |
| lock_state | output | 8 | Current lock bits |

## Verification
The assertions assume that the write strobe, enable, address and data are stable around the clock edge. They also assume that reset is the only way the lock bits may fall, which is why every property is disabled during reset. The bench changes inputs only on the falling edge. It keeps the address inside the 3-bit space and covers all eight offsets, mapped and unmapped. Writes are issued both with and without the protected enable, so each lock and protection case is reached from a legal bus cycle.

// File: rtl/amp_cfg_pkg.sv
package amp_cfg_pkg;

    parameter int BUS_W  = 32;
    parameter int LOCK_W = 8;

    localparam int NUM_SLOTS  = 5;
    localparam int NUM_GUARDED = 3;

    typedef enum int {
        SLOT_CTRL = 0,
        SLOT_MUX  = 1,
        SLOT_TRIM = 2,
        SLOT_ID   = 3,
        SLOT_LOCK = 4
    } slot_e;

    localparam logic [BUS_W-1:0]  ID_WORD        = 32'h0000_0201;
    localparam logic [LOCK_W-1:0] LOCK_SET_MASK  = 8'h8F;

    // Word offset of every mapped slot
    function automatic int slot_offset(input int s);
        case (s)
            SLOT_CTRL: return 0;
            SLOT_MUX:  return 1;
            SLOT_TRIM: return 2;
            SLOT_ID:   return 5;
            SLOT_LOCK: return 6;
            default:   return -1;
        endcase
    endfunction

    // Writable bits of each guarded register
    function automatic logic [BUS_W-1:0] field_mask(input int s);
        case (s)
            SLOT_CTRL: return 32'h0000_83EF;
            SLOT_MUX:  return 32'h0000_7773;
            SLOT_TRIM: return 32'h00FF_00FF;
            default:   return '0;
        endcase
    endfunction

    // Bit positions of the decoded fields
    localparam int CT_EN    = 0;
    localparam int CT_FILT  = 1;
    localparam int CT_GAIN  = 5;
    localparam int CT_OUT   = 8;
    localparam int CT_GPIN  = 9;
    localparam int CT_CHOP  = 15;
    localparam int MX_POS   = 0;
    localparam int MX_NEG   = 4;
    localparam int MX_M     = 8;
    localparam int MX_FB    = 12;
    localparam int MX_CHOP  = 13;
    localparam int TR_N     = 0;
    localparam int TR_P     = 16;

endpackage

// File: rtl/amp_cfg_decode.sv
module amp_cfg_decode
    import amp_cfg_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic [ADDR_W-1:0]    addr,
    output logic [NUM_SLOTS-1:0] hit
);

    genvar s;
    generate
        for (s = 0; s < NUM_SLOTS; s++) begin : g_slot
            assign hit[s] = (int'(addr) == slot_offset(s));
        end
    endgenerate

endmodule

// File: rtl/amp_cfg_field.sv
module amp_cfg_field #(
    parameter int          W    = 32,
    parameter logic [W-1:0] MASK = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (we) begin
            q <= wdata & MASK;
        end
    end

endmodule

// File: rtl/amp_cfg_lock.sv
module amp_cfg_lock #(
    parameter int           W        = 8,
    parameter logic [W-1:0] SET_MASK = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         set_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (set_en) begin
            q <= q | (wdata & SET_MASK);
        end
    end

endmodule

// File: rtl/amp_cfg_bank.sv
module amp_cfg_bank
    import amp_cfg_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic              prot_en,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              amp_en,
    output logic [2:0]        filt_sel,
    output logic [2:0]        gain_code,
    output logic              out_en,
    output logic              gain_pin_en,
    output logic              chop_level,
    output logic [1:0]        pos_sel,
    output logic [2:0]        neg_sel,
    output logic [2:0]        m_sel,
    output logic              fb_on_pin,
    output logic [1:0]        chop_mode,
    output logic [7:0]        trim_p,
    output logic [7:0]        trim_n,
    output logic [LOCK_W-1:0] lock_state
);

    logic [NUM_SLOTS-1:0] hit;
    logic [BUS_W-1:0]     slot_val [NUM_SLOTS];
    logic [LOCK_W-1:0]    lock_q;
    logic                 wr_ok;

    assign wr_ok = bus_wr & prot_en;

    amp_cfg_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .hit  (hit)
    );

    genvar g;
    generate
        for (g = 0; g < NUM_GUARDED; g++) begin : g_reg
            logic we_g;
            assign we_g = wr_ok & hit[g] & ~lock_q[g];
            amp_cfg_field #(.W(BUS_W), .MASK(field_mask(g))) u_field (
                .clk   (clk),
                .rst   (rst),
                .we    (we_g),
                .wdata (bus_wdata),
                .q     (slot_val[g])
            );
        end
    endgenerate

    amp_cfg_lock #(.W(LOCK_W), .SET_MASK(LOCK_SET_MASK)) u_lock (
        .clk    (clk),
        .rst    (rst),
        .set_en (wr_ok & hit[SLOT_LOCK]),
        .wdata  (bus_wdata[LOCK_W-1:0]),
        .q      (lock_q)
    );

    assign slot_val[SLOT_ID]   = ID_WORD;
    assign slot_val[SLOT_LOCK] = {{(BUS_W-LOCK_W){1'b0}}, lock_q};

    always_comb begin
        bus_rdata = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            bus_rdata = bus_rdata | ({BUS_W{hit[s]}} & slot_val[s]);
        end
    end

    assign amp_en      = slot_val[SLOT_CTRL][CT_EN];
    assign filt_sel    = slot_val[SLOT_CTRL][CT_FILT +: 3];
    assign gain_code   = slot_val[SLOT_CTRL][CT_GAIN +: 3];
    assign out_en      = slot_val[SLOT_CTRL][CT_OUT];
    assign gain_pin_en = slot_val[SLOT_CTRL][CT_GPIN];
    assign chop_level  = slot_val[SLOT_CTRL][CT_CHOP];
    assign pos_sel     = slot_val[SLOT_MUX][MX_POS +: 2];
    assign neg_sel     = slot_val[SLOT_MUX][MX_NEG +: 3];
    assign m_sel       = slot_val[SLOT_MUX][MX_M +: 3];
    assign fb_on_pin   = slot_val[SLOT_MUX][MX_FB];
    assign chop_mode   = slot_val[SLOT_MUX][MX_CHOP +: 2];
    assign trim_n      = slot_val[SLOT_TRIM][TR_N +: 8];
    assign trim_p      = slot_val[SLOT_TRIM][TR_P +: 8];
    assign lock_state  = lock_q;

endmodule

// File: rtl/amp_cfg_bank_chk.sv
module amp_cfg_bank_chk (
    input logic        clk,
    input logic        rst,
    input logic [2:0]  bus_addr,
    input logic        prot_en,
    input logic [31:0] bus_rdata,
    input logic [15:0] ctrl_view,
    input logic [15:0] mux_view,
    input logic [15:0] trim_view,
    input logic [7:0]  lock_state
);

    // R8: identification word is constant
    a_r8_id_const: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 3'd5) |-> (bus_rdata == 32'h0000_0201));

    // R9: unmapped offsets read zero
    a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 3'd3 || bus_addr == 3'd4 || bus_addr == 3'd7) |-> (bus_rdata == 32'h0));

    // R2: reserved control bits read zero
    a_r2_ctrl_reserved: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 3'd0) |-> ((bus_rdata & ~32'h0000_83EF) == 32'h0));

    // R5: no change without protected enable
    a_r5_no_prot_stable: assert property (@(posedge clk) disable iff (rst)
        !prot_en |=> ($stable(ctrl_view) && $stable(mux_view) && $stable(trim_view) && $stable(lock_state)));

    // R6: locked registers hold
    a_r6_ctrl_locked: assert property (@(posedge clk) disable iff (rst)
        lock_state[0] |=> $stable(ctrl_view));
    a_r6_mux_locked: assert property (@(posedge clk) disable iff (rst)
        lock_state[1] |=> $stable(mux_view));
    a_r6_trim_locked: assert property (@(posedge clk) disable iff (rst)
        lock_state[2] |=> $stable(trim_view));

    // R7: lock bits never fall outside reset, reserved ones stay zero
    a_r7_lock_sticky: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((lock_state & $past(lock_state)) == $past(lock_state)));
    a_r7_lock_reserved: assert property (@(posedge clk) disable iff (rst)
        lock_state[6:4] == 3'b000);

endmodule

bind amp_cfg_bank amp_cfg_bank_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .prot_en    (prot_en),
    .bus_rdata  (bus_rdata),
    .ctrl_view  ({chop_level, gain_pin_en, out_en, gain_code, filt_sel, amp_en, 6'd0}),
    .mux_view   ({chop_mode, fb_on_pin, m_sel, neg_sel, pos_sel, 5'd0}),
    .trim_view  ({trim_p, trim_n}),
    .lock_state (lock_state)
);

// File: tb/amp_cfg_bank_bench.sv
module amp_cfg_bank_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        prot_en = 1'b0;
    logic [31:0] bus_rdata;
    logic        amp_en, out_en, gain_pin_en, chop_level, fb_on_pin;
    logic [2:0]  filt_sel, gain_code, neg_sel, m_sel;
    logic [1:0]  pos_sel, chop_mode;
    logic [7:0]  trim_p, trim_n, lock_state;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    // reference state
    logic [15:0] m_ctrl, m_mux;
    logic [31:0] m_trim;
    logic [7:0]  m_lock;

    always #5 clk = ~clk;

    amp_cfg_bank u_amp_cfg_bank (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .prot_en(prot_en), .bus_rdata(bus_rdata),
        .amp_en(amp_en), .filt_sel(filt_sel), .gain_code(gain_code),
        .out_en(out_en), .gain_pin_en(gain_pin_en), .chop_level(chop_level),
        .pos_sel(pos_sel), .neg_sel(neg_sel), .m_sel(m_sel),
        .fb_on_pin(fb_on_pin), .chop_mode(chop_mode), .trim_p(trim_p),
        .trim_n(trim_n), .lock_state(lock_state)
    );

    function automatic logic [31:0] exp_read(input logic [2:0] a);
        case (a)
            3'd0: return {16'h0, m_ctrl};
            3'd1: return {16'h0, m_mux};
            3'd2: return m_trim;
            3'd5: return 32'h0000_0201;
            3'd6: return {24'h0, m_lock};
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [63:0] exp_fields();
        return {19'h0, m_ctrl[0], m_ctrl[3:1], m_ctrl[7:5], m_ctrl[8], m_ctrl[9], m_ctrl[15],
                m_mux[1:0], m_mux[6:4], m_mux[10:8], m_mux[12], m_mux[14:13],
                m_trim[23:16], m_trim[7:0], m_lock};
    endfunction

    function automatic logic [63:0] act_fields();
        return {19'h0, amp_en, filt_sel, gain_code, out_en, gain_pin_en, chop_level,
                pos_sel, neg_sel, m_sel, fb_on_pin, chop_mode, trim_p, trim_n, lock_state};
    endfunction

    task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // one bus cycle: drive at falling edge, update model at rising, compare at next falling
    task automatic cycle(input string tag, input logic r, input logic [2:0] a,
                         input logic w, input logic [31:0] d, input logic p);
        rst = r; bus_addr = a; bus_wr = w; bus_wdata = d; prot_en = p;
        @(posedge clk);
        if (r) begin
            m_ctrl = '0; m_mux = '0; m_trim = '0; m_lock = '0;
        end else if (w && p) begin
            if (a == 3'd0 && !m_lock[0]) m_ctrl = d[15:0] & 16'h83EF;
            if (a == 3'd1 && !m_lock[1]) m_mux  = d[15:0] & 16'h7773;
            if (a == 3'd2 && !m_lock[2]) m_trim = d & 32'h00FF_00FF;
            if (a == 3'd6)               m_lock = m_lock | (d[7:0] & 8'h8F);
        end
        @(negedge clk);
        check(tag, "fields", act_fields(), exp_fields());
        check(tag, "rdata", {32'h0, bus_rdata}, {32'h0, exp_read(a)});
    endtask

    task automatic rd(input string tag, input logic [2:0] a);
        cycle(tag, 1'b0, a, 1'b0, 32'h0, 1'b0);
    endtask

    task automatic wr(input string tag, input logic [2:0] a, input logic [31:0] d, input logic p);
        cycle(tag, 1'b0, a, 1'b1, d, p);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        m_ctrl = '0; m_mux = '0; m_trim = '0; m_lock = '0;
        @(negedge clk);
        cycle("R1", 1'b1, 3'd0, 1'b0, 32'h0, 1'b0);
        cycle("R1", 1'b1, 3'd0, 1'b0, 32'h0, 1'b0);
        for (int a = 0; a < 8; a++) rd("R1", 3'(a));

        // R2 control register
        wr("R2", 3'd0, 32'hFFFF_FFFF, 1'b1);
        rd("R2", 3'd0);
        wr("R2", 3'd0, 32'h0000_1234, 1'b1);
        wr("R2", 3'd0, 32'h0000_80A5, 1'b1);
        rd("R2", 3'd0);

        // R3 mux register
        wr("R3", 3'd1, 32'hFFFF_FFFF, 1'b1);
        rd("R3", 3'd1);
        wr("R3", 3'd1, 32'h0000_A5A5, 1'b1);
        wr("R3", 3'd1, 32'h0000_5A5A, 1'b1);

        // R4 trim register
        wr("R4", 3'd2, 32'hFFFF_FFFF, 1'b1);
        rd("R4", 3'd2);
        wr("R4", 3'd2, 32'h1234_5678, 1'b1);
        rd("R4", 3'd2);

        // R5 unprotected writes
        wr("R5", 3'd0, 32'h0000_0000, 1'b0);
        wr("R5", 3'd1, 32'h0000_0000, 1'b0);
        wr("R5", 3'd2, 32'h0000_0000, 1'b0);
        wr("R5", 3'd6, 32'h0000_00FF, 1'b0);
        rd("R5", 3'd6);

        // R8 id register ignores writes
        wr("R8", 3'd5, 32'hFFFF_FFFF, 1'b1);
        rd("R8", 3'd5);

        // R9 unmapped offsets
        wr("R9", 3'd3, 32'hFFFF_FFFF, 1'b1);
        wr("R9", 3'd4, 32'hFFFF_FFFF, 1'b1);
        wr("R9", 3'd7, 32'hFFFF_FFFF, 1'b1);
        rd("R9", 3'd3);
        rd("R9", 3'd7);

        // R6 per-register locks
        wr("R6", 3'd6, 32'h0000_0001, 1'b1);
        wr("R6", 3'd0, 32'h0000_0000, 1'b1);
        rd("R6", 3'd0);
        wr("R6", 3'd1, 32'h0000_0003, 1'b1);
        wr("R6", 3'd6, 32'h0000_0002, 1'b1);
        wr("R6", 3'd1, 32'h0000_7000, 1'b1);
        wr("R6", 3'd2, 32'h00AA_0055, 1'b1);
        wr("R6", 3'd6, 32'h0000_0004, 1'b1);
        wr("R6", 3'd2, 32'h0000_0000, 1'b1);
        rd("R6", 3'd2);

        // R7 set-once behaviour and reserved lock bits
        wr("R7", 3'd6, 32'h0000_0000, 1'b1);
        rd("R7", 3'd6);
        wr("R7", 3'd6, 32'hFFFF_FFFF, 1'b1);
        rd("R7", 3'd6);

        // R10 reset releases locks
        cycle("R10", 1'b1, 3'd6, 1'b0, 32'h0, 1'b0);
        rd("R10", 3'd6);
        wr("R10", 3'd0, 32'h0000_8001, 1'b1);
        wr("R10", 3'd1, 32'h0000_1001, 1'b1);
        wr("R10", 3'd2, 32'h0001_0080, 1'b1);
        rd("R10", 3'd0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule